// File: doc/BRIEF.md
# Pipelined Two's Complement Array Multiplier

This block multiplies two signed 8-bit operands and returns the full signed 16-bit product. It is a bit-level pipeline that accepts a new operand pair on every clock and delivers each product a fixed 12 clock edges later. Products leave in the same order as the pairs entered. A valid flag travels through every stage beside the data, so a caller can stream pairs continuously, leave idle cycles, or mix the two.

Sign handling follows the Baugh-Wooley scheme. In the partial-product terms that combine exactly one sign bit, the AND becomes a NAND. Two constant ones are then folded into the array, one at weight 2^8 and one at weight 2^15. The summing array has one carry-save row of full adders for each multiplier bit, with a register behind every row. Multiplier bit i is delayed by i cycles so it reaches row i with its own operand pair. Product bit i settles in row i and is then held in a deskew chain until the upper half is ready. A three-stage carry-propagate merge adder forms the upper half. The stage count is: one input register, eight array rows, and three merge stages. The block is a pure datapath, so it has no state machine.

Top module: `bwm_mult_pipe`

## Requirements
- R1: When out_valid is 1, out_prod holds the exact signed 16-bit product of the in_a and in_b pair that was accepted with it.
- R2: A pair sampled at a rising edge with in_valid = 1 is presented, with out_valid = 1, right after the 12th rising edge, counting the sampling edge as the first. At every edge, out_valid equals in_valid as sampled 12 edges earlier.
- R3: A new pair is accepted at every rising edge. Pairs given on consecutive cycles come out on consecutive cycles, in input order.
- R4: The most negative operand squared, 0x80 × 0x80 (−128 × −128), gives 0x4000 (+16384).
- R5: 0x80 × 0x7F and 0x7F × 0x80 both give 0xC080 (−16256). Whenever both operands are nonzero, bit 15 of the product equals the XOR of the two operand sign bits (bit 7).
- R6: If either operand is 0x00, the product is 0x0000, whatever the value of the other operand.
- R7: A cycle with in_valid = 0 gives out_valid = 0 in the matching output slot, 12 edges later. Valid pairs on either side of such a gap keep their products and their order.
- R8: rst_n is active low and acts asynchronously. While it is low, out_valid and out_prod are 0. Every pair still in flight when reset arrives is discarded: if no new pair enters, out_valid stays 0 for at least 12 edges after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks in_a and in_b as a pair to multiply |
| in_a | input | 8 | Multiplicand, two's complement |
| in_b | input | 8 | Multiplier, two's complement |
| out_valid | output | 1 | out_prod carries a product this cycle |
| out_prod | output | 16 | Product, two's complement |

## Verification
The hardest condition to reach from the ports is a reset that lands while every array row, deskew chain and merge stage holds live work. The bench creates it by streaming valid pairs and pulling rst_n low mid-stream. It then watches 13 idle cycles for any stale out_valid. The sign-term inversion and the two injected constants only matter together when the sign bits of both operands are set. For this reason the directed corner stream sends 0x80 and 0x7F in every combination back to back, and a long pseudo-random stream follows it.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    // One full-adder cell: returns {carry, sum}
    function automatic logic [1:0] fa(input logic x, input logic y, input logic z);
        return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
    endfunction

endpackage

// File: rtl/bwm_delay_line.sv
module bwm_delay_line #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] taps [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
        end else begin
            taps[0] <= d;
            for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
        end
    end

    assign q = taps[DEPTH-1];

endmodule

// File: rtl/bwm_csa_row.sv
module bwm_csa_row
    import bwm_pkg::*;
#(
    parameter int W   = 8,
    parameter int ROW = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    input  logic [W-1:0] a_i,
    input  logic         b_i,
    input  logic [W-1:0] ps_i,
    input  logic [W-1:0] pc_i,
    output logic         v_o,
    output logic [W-1:0] a_o,
    output logic [W-1:0] ps_o,
    output logic [W-1:0] pc_o,
    output logic         lo_o
);

    localparam bit SIGN_ROW = (ROW == W - 1);
    // free top slot of the shifted sum carries the constants 2^W and 2^(2W-1)
    localparam bit INJECT   = (ROW == 0) || (ROW == W - 1);

    logic [W-1:0] pp, s, co, ps_n;

    always_comb begin
        for (int j = 0; j < W; j++) begin
            pp[j] = a_i[j] & b_i;
            if (SIGN_ROW != (j == W - 1)) pp[j] = ~pp[j];
            {co[j], s[j]} = fa(pp[j], ps_i[j], pc_i[j]);
        end
        ps_n = {INJECT, s[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o  <= 1'b0;
            a_o  <= '0;
            ps_o <= '0;
            pc_o <= '0;
            lo_o <= 1'b0;
        end else begin
            v_o  <= v_i;
            a_o  <= a_i;
            ps_o <= ps_n;
            pc_o <= co;
            lo_o <= s[0];
        end
    end

endmodule

// File: rtl/bwm_merge_stage.sv
module bwm_merge_stage
    import bwm_pkg::*;
#(
    parameter int W   = 8,
    parameter int CW  = 3,
    parameter int IDX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] c_i,
    input  logic [W-1:0] r_i,
    input  logic         cy_i,
    input  logic [W-1:0] lo_i,
    output logic         v_o,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o,
    output logic [W-1:0] r_o,
    output logic         cy_o,
    output logic [W-1:0] lo_o
);

    logic [W-1:0] r_n;
    logic         cy;

    always_comb begin
        r_n = r_i;
        cy  = cy_i;
        for (int j = 0; j < W; j++) begin
            if (j / CW == IDX) {cy, r_n[j]} = fa(s_i[j], c_i[j], cy);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o  <= 1'b0;
            s_o  <= '0;
            c_o  <= '0;
            r_o  <= '0;
            cy_o <= 1'b0;
            lo_o <= '0;
        end else begin
            v_o  <= v_i;
            s_o  <= s_i;
            c_o  <= c_i;
            r_o  <= r_n;
            cy_o <= cy;
            lo_o <= lo_i;
        end
    end

endmodule

// File: rtl/bwm_mult_pipe.sv
module bwm_mult_pipe #(
    parameter int W  = 8,
    parameter int MS = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    output logic           out_valid,
    output logic [2*W-1:0] out_prod
);

    localparam int CW  = (W + MS - 1) / MS;
    localparam int LAT = 1 + W + MS;

    // input register
    logic         in_v_q;
    logic [W-1:0] in_a_q, in_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_v_q <= 1'b0;
            in_a_q <= '0;
            in_b_q <= '0;
        end else begin
            in_v_q <= in_valid;
            in_a_q <= in_a;
            in_b_q <= in_b;
        end
    end

    // multiplier-bit skew: bit i waits i cycles to meet row i
    logic b_skw [W];

    for (genvar i = 0; i < W; i++) begin : g_skew
        if (i == 0) begin : g_direct
            assign b_skw[i] = in_b_q[i];
        end else begin : g_delay
            bwm_delay_line #(.WIDTH(1), .DEPTH(i)) dly_i (
                .clk (clk),
                .rst_n (rst_n),
                .d (in_b_q[i]),
                .q (b_skw[i])
            );
        end
    end

    // carry-save array rows
    logic         v_r  [W];
    logic [W-1:0] a_r  [W];
    logic [W-1:0] ps_r [W];
    logic [W-1:0] pc_r [W];
    logic         lo_r [W];

    for (genvar i = 0; i < W; i++) begin : g_row
        if (i == 0) begin : g_first
            bwm_csa_row #(.W(W), .ROW(i)) row_i (
                .clk (clk), .rst_n (rst_n),
                .v_i (in_v_q), .a_i (in_a_q), .b_i (b_skw[i]),
                .ps_i ('0), .pc_i ('0),
                .v_o (v_r[i]), .a_o (a_r[i]), .ps_o (ps_r[i]),
                .pc_o (pc_r[i]), .lo_o (lo_r[i])
            );
        end else begin : g_next
            bwm_csa_row #(.W(W), .ROW(i)) row_i (
                .clk (clk), .rst_n (rst_n),
                .v_i (v_r[i-1]), .a_i (a_r[i-1]), .b_i (b_skw[i]),
                .ps_i (ps_r[i-1]), .pc_i (pc_r[i-1]),
                .v_o (v_r[i]), .a_o (a_r[i]), .ps_o (ps_r[i]),
                .pc_o (pc_r[i]), .lo_o (lo_r[i])
            );
        end
    end

    // low product bits: bit i waits W-1-i cycles to line up with the last row
    logic         lo_al [W];
    logic [W-1:0] lo_vec;

    for (genvar i = 0; i < W; i++) begin : g_deskew
        if (i == W - 1) begin : g_direct
            assign lo_al[i] = lo_r[i];
        end else begin : g_delay
            bwm_delay_line #(.WIDTH(1), .DEPTH(W - 1 - i)) dly_i (
                .clk (clk),
                .rst_n (rst_n),
                .d (lo_r[i]),
                .q (lo_al[i])
            );
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) lo_vec[i] = lo_al[i];
    end

    // pipelined merge of the upper half
    logic         mg_v  [MS];
    logic [W-1:0] mg_s  [MS];
    logic [W-1:0] mg_c  [MS];
    logic [W-1:0] mg_r  [MS];
    logic         mg_cy [MS];
    logic [W-1:0] mg_lo [MS];

    for (genvar k = 0; k < MS; k++) begin : g_merge
        if (k == 0) begin : g_first
            bwm_merge_stage #(.W(W), .CW(CW), .IDX(k)) stg_i (
                .clk (clk), .rst_n (rst_n),
                .v_i (v_r[W-1]), .s_i (ps_r[W-1]), .c_i (pc_r[W-1]),
                .r_i ('0), .cy_i (1'b0), .lo_i (lo_vec),
                .v_o (mg_v[k]), .s_o (mg_s[k]), .c_o (mg_c[k]),
                .r_o (mg_r[k]), .cy_o (mg_cy[k]), .lo_o (mg_lo[k])
            );
        end else begin : g_next
            bwm_merge_stage #(.W(W), .CW(CW), .IDX(k)) stg_i (
                .clk (clk), .rst_n (rst_n),
                .v_i (mg_v[k-1]), .s_i (mg_s[k-1]), .c_i (mg_c[k-1]),
                .r_i (mg_r[k-1]), .cy_i (mg_cy[k-1]), .lo_i (mg_lo[k-1]),
                .v_o (mg_v[k]), .s_o (mg_s[k]), .c_o (mg_c[k]),
                .r_o (mg_r[k]), .cy_o (mg_cy[k]), .lo_o (mg_lo[k])
            );
        end
    end

    // leftovers past the final stage carry no information (carry out of 2^(2W) is dropped)
    logic tail_unused;
    assign tail_unused = ^{mg_s[MS-1], mg_c[MS-1], mg_cy[MS-1], a_r[W-1], LAT[0]};

    assign out_valid = mg_v[MS-1];
    assign out_prod  = {mg_r[MS-1], mg_lo[MS-1]};

endmodule

// File: rtl/bwm_mult_chk.sv
module bwm_mult_chk #(
    parameter int W  = 8,
    parameter int MS = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [W-1:0]   in_a,
    input logic [W-1:0]   in_b,
    input logic           out_valid,
    input logic [2*W-1:0] out_prod
);

    localparam int LAT = 1 + W + MS;
    localparam logic [W-1:0]   MINV  = {1'b1, {(W-1){1'b0}}};
    localparam logic [2*W-1:0] MINSQ = {2'b01, {(2*W-2){1'b0}}};

    logic         vh [LAT];
    logic [W-1:0] ah [LAT];
    logic [W-1:0] bh [LAT];
    int unsigned  since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                vh[i] <= 1'b0;
                ah[i] <= '0;
                bh[i] <= '0;
            end
            since_rst <= 0;
        end else begin
            vh[0] <= in_valid;
            ah[0] <= in_a;
            bh[0] <= in_b;
            for (int i = 1; i < LAT; i++) begin
                vh[i] <= vh[i-1];
                ah[i] <= ah[i-1];
                bh[i] <= bh[i-1];
            end
            if (since_rst < LAT) since_rst <= since_rst + 1;
        end
    end

    logic signed [2*W-1:0] exp_p;
    assign exp_p = $signed(ah[LAT-1]) * $signed(bh[LAT-1]);

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vh[LAT-1]);

    // R1
    product_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_prod == exp_p);

    // R4
    min_square_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ah[LAT-1] == MINV && bh[LAT-1] == MINV) |-> out_prod == MINSQ);

    // R5
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ah[LAT-1] != '0 && bh[LAT-1] != '0)
            |-> out_prod[2*W-1] == (ah[LAT-1][W-1] ^ bh[LAT-1][W-1]));

    // R6
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (ah[LAT-1] == '0 || bh[LAT-1] == '0)) |-> out_prod == '0);

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < LAT) |-> !out_valid);

endmodule

bind bwm_mult_pipe bwm_mult_chk #(.W(W), .MS(MS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_prod  (out_prod)
);

// File: tb/bwm_mult_pipe_tb_top.sv
module bwm_mult_pipe_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 12;
    localparam int WDOG       = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_a, in_b;
    logic        out_valid;
    logic [15:0] out_prod;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0]  sa [64];
    logic [7:0]  sb [64];
    logic        sv [64];
    logic [15:0] sx [64];
    string       stag [64];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bwm_mult_pipe dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    function automatic logic [15:0] ref_mul(logic [7:0] a, logic [7:0] b);
        logic signed [15:0] p;
        p = $signed(a) * $signed(b);
        return p;
    endfunction

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        in_valid = 1'b0;
        in_a     = 8'h00;
        in_b     = 8'h00;
    endtask

    // drives n entries at successive negedges, checks each slot 12 cycles later
    task automatic run_stream(string vtag, int n);
        for (int t = 0; t < n + LAT; t++) begin
            @(negedge clk);
            if (t >= LAT) begin
                int k = t - LAT;
                chk(vtag, "valid slot", 16'(out_valid), 16'(sv[k]));
                if (sv[k]) chk(stag[k], "product", out_prod, sx[k]);
            end
            if (t < n) begin
                in_valid = sv[t];
                in_a     = sa[t];
                in_b     = sb[t];
            end else begin
                drive_idle();
            end
        end
    endtask

    task automatic set_pair(int k, logic [7:0] a, logic [7:0] b, logic [15:0] x, string tag);
        sa[k] = a; sb[k] = b; sv[k] = 1'b1; sx[k] = x; stag[k] = tag;
    endtask

    task automatic t_reset_state();
        // R8: held in reset, outputs are cleared
        chk("R8", "out_valid in reset", 16'(out_valid), 16'h0000);
        chk("R8", "out_prod in reset", out_prod, 16'h0000);
    endtask

    task automatic t_corners();
        set_pair(0, 8'h80, 8'h80, 16'h4000, "R4");
        set_pair(1, 8'h80, 8'h7F, 16'hC080, "R5");
        set_pair(2, 8'h7F, 8'h80, 16'hC080, "R5");
        set_pair(3, 8'h7F, 8'h7F, 16'h3F01, "R1");
        set_pair(4, 8'hFF, 8'hFF, 16'h0001, "R1");
        set_pair(5, 8'h00, 8'h5A, 16'h0000, "R6");
        set_pair(6, 8'hA5, 8'h00, 16'h0000, "R6");
        set_pair(7, 8'h01, 8'h80, 16'hFF80, "R5");
        set_pair(8, 8'hFF, 8'h80, 16'h0080, "R5");
        set_pair(9, 8'h00, 8'h80, 16'h0000, "R6");
        set_pair(10, 8'h80, 8'h00, 16'h0000, "R6");
        // back-to-back delivery order, R3
        run_stream("R3", 11);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            set_pair(k, lfsr[7:0], lfsr[15:8], ref_mul(lfsr[7:0], lfsr[15:8]), "R1");
        end
        run_stream("R3", 40);
    endtask

    task automatic t_bubbles();
        for (int k = 0; k < 18; k++) begin
            set_pair(k, 8'(8'h13 * k + 8'h81), 8'(8'h29 * k + 8'h47),
                     ref_mul(8'(8'h13 * k + 8'h81), 8'(8'h29 * k + 8'h47)), "R7");
            sv[k] = (k % 3) != 1;
        end
        run_stream("R7", 18);
    endtask

    task automatic t_reset_midflight();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_a     = 8'(8'h80 + k);
            in_b     = 8'(8'h7F - k);
        end
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8", "out_valid after mid-flight reset", 16'(out_valid), 16'h0000);
        chk("R8", "out_prod after mid-flight reset", out_prod, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < LAT + 1; t++) begin
            @(negedge clk);
            chk("R8", "stale valid after release", 16'(out_valid), 16'h0000);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        drive_idle();
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_corners();
        t_bubbles();
        t_sweep();
        t_reset_midflight();
        t_corners();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule